// File: doc/BRIEF.md
# Radio Transmit Start Sequencer

This block is the control core that turns a transmit request into a safely ordered power-up of a packet radio's output stages. It keeps the radio's operating state: off, synthesizer-locked ready, or retry-capable ready. It accepts a start request from either of two paths. One is a rising edge on a dedicated trigger input. The other is a start code written into the command field. A request is accepted only while one of the two ready states is held and the frame data is flagged complete.

Once a request is accepted, the reported state switches to the busy-transmit code. The amplifier buffer is enabled at once and the amplifier itself a configurable number of cycles later. The baseband modulator is released a fixed number of cycles after the accepting edge; the default of 256 cycles is 16 µs at a 16 MHz clock. When the modulator signals that the frame is out, the stages power down in reverse order. The state then returns to the ready state the transmission began from, and a one-cycle completion pulse is issued. A start request that arrives during a transmission is dropped and latches an error flag until software clears it.

Top module: `tx_start_seq`

## Requirements
- R1: After synchronous reset, `state_code` reads 0x08 (off), `err_flag`, `tx_done`, `pa_buf_en`, `pa_en` and `mod_en` are all 0.
- R2: Outside busy-transmit, writing command 0x08, 0x09 or 0x19 sets `state_code` to that value at the next clock edge; any other command code except 0x02 leaves the state unchanged.
- R3: A start request is accepted only when `state_code` is 0x09 or 0x19 and `frame_ok` is 1; on acceptance `state_code` reads 0x12 after the accepting edge, and otherwise the request changes nothing.
- R4: A start request is either a sampled 0-to-1 transition of `trig_in` or a command write of 0x02; holding `trig_in` high does not start another transmission.
- R5: `pa_buf_en` rises at the accepting edge and `pa_en` rises exactly `BUF_LEAD` cycles later; `pa_en` is never 1 while `pa_buf_en` is 0.
- R6: `mod_en` rises exactly `START_DLY` cycles after the accepting edge.
- R7: With `mod_en` at 1, a `mod_done` pulse clears `pa_en` and `mod_en` at the next edge; `pa_buf_en` clears `FALL_GAP` cycles later. At that same edge `state_code` returns to the ready code held before the transmission and `tx_done` pulses for one cycle.
- R8: A start request while in busy-transmit is dropped without disturbing the transmission and sets `err_flag`; `err_clr` clears it, and a set in the same cycle wins.
- R9: `mod_done` while `mod_en` is 0 has no effect.
- R10: State commands written during busy-transmit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Dedicated start trigger, rising edge starts |
| cmd_we | input | 1 | Command field write strobe |
| cmd_val | input | 8 | Command code written |
| frame_ok | input | 1 | Frame data complete and valid |
| mod_done | input | 1 | Modulator reports frame sent |
| err_clr | input | 1 | Software clear of the error flag |
| state_code | output | 8 | Current radio state code |
| pa_buf_en | output | 1 | Amplifier buffer enable |
| pa_en | output | 1 | Power amplifier enable |
| mod_en | output | 1 | Baseband modulator release |
| tx_done | output | 1 | One-cycle transmission complete pulse |
| err_flag | output | 1 | Sticky start-while-busy error |

## Verification
The bench builds the block with `START_DLY` of 20, `BUF_LEAD` of 7 and `FALL_GAP` of 3 instead of the 16 µs defaults. Every full start-to-done sequence therefore lasts only a few dozen cycles. The short window lets each run check both ramp edges to the exact cycle, and lets dozens of random transmissions mix origin states, trigger paths, frame-valid values and injected busy-time requests.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

    typedef enum logic [1:0] {
        RS_OFF   = 2'd0,
        RS_PLL   = 2'd1,
        RS_RETRY = 2'd2,
        RS_BUSY  = 2'd3
    } radio_st_e;

    typedef enum logic {
        PH_RAMP = 1'b0,
        PH_FALL = 1'b1
    } tx_phase_e;

    localparam logic [7:0] CODE_OFF   = 8'h08;
    localparam logic [7:0] CODE_PLL   = 8'h09;
    localparam logic [7:0] CODE_RETRY = 8'h19;
    localparam logic [7:0] CODE_BUSY  = 8'h12;
    localparam logic [7:0] CMD_START  = 8'h02;

    typedef struct packed {
        logic      start;
        logic      go_valid;
        radio_st_e go_tgt;
    } tx_req_t;

    typedef struct packed {
        logic buf_en;
        logic pa_en;
        logic mod_en;
    } amp_ctl_t;

    function automatic logic [7:0] st_to_code(input radio_st_e s);
        case (s)
            RS_PLL:   return CODE_PLL;
            RS_RETRY: return CODE_RETRY;
            RS_BUSY:  return CODE_BUSY;
            default:  return CODE_OFF;
        endcase
    endfunction

    function automatic tx_req_t decode_go(input logic we, input logic [7:0] c);
        tx_req_t r;
        r.start    = 1'b0;
        r.go_valid = 1'b0;
        r.go_tgt   = RS_OFF;
        if (we) begin
            case (c)
                CODE_OFF:   begin r.go_valid = 1'b1; r.go_tgt = RS_OFF;   end
                CODE_PLL:   begin r.go_valid = 1'b1; r.go_tgt = RS_PLL;   end
                CODE_RETRY: begin r.go_valid = 1'b1; r.go_tgt = RS_RETRY; end
                default:    r.go_valid = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/tx_seq_trigger.sv
module tx_seq_trigger
    import tx_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_in,
    input  logic       cmd_we,
    input  logic [7:0] cmd_val,
    output tx_req_t    req
);
    logic trig_q;
    logic trig_rise;
    logic cmd_start;
    tx_req_t go;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    assign trig_rise = trig_in & ~trig_q;
    assign cmd_start = cmd_we && (cmd_val == CMD_START);
    assign go        = decode_go(cmd_we, cmd_val);

    always_comb begin
        req          = go;
        req.start    = trig_rise | cmd_start;
    end

    // R4: a level held high over two samples never yields a start by itself
    assert_hold_no_restart_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(trig_in) && trig_in && !cmd_we) |-> !req.start);

endmodule

// File: rtl/tx_seq_timer.sv
module tx_seq_timer #(
    parameter int unsigned LIMIT = 256,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end

    // R6: the delay count saturates and never passes its limit
    assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CMAX);

    // R6: a clear always restarts the window from zero
    assert_clr_restarts_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

endmodule

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
    import tx_seq_pkg::*;
#(
    parameter int unsigned START_DLY = 256,
    parameter int unsigned BUF_LEAD  = 128,
    parameter int unsigned FALL_GAP  = 4,
    localparam int unsigned CW       = $clog2(START_DLY + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  tx_req_t       req,
    input  logic          frame_ok,
    input  logic          mod_done,
    input  logic          err_clr,
    input  logic [CW-1:0] cnt,
    output logic          timer_clr,
    output radio_st_e     st,
    output amp_ctl_t      amp,
    output logic          tx_done,
    output logic          err_flag
);
    localparam logic [CW-1:0] LEAD_C = CW'(BUF_LEAD);
    localparam logic [CW-1:0] DLY_C  = CW'(START_DLY);
    localparam logic [CW-1:0] FALL_C = CW'(FALL_GAP - 1);

    tx_phase_e phase;
    radio_st_e origin;
    logic      ready;
    logic      accept;
    logic      finish;
    logic      fall_end;

    assign ready    = (st == RS_PLL) || (st == RS_RETRY);
    assign accept   = ready && req.start && frame_ok;
    assign finish   = (st == RS_BUSY) && (phase == PH_RAMP) && mod_done && amp.mod_en;
    assign fall_end = (st == RS_BUSY) && (phase == PH_FALL) && (cnt == FALL_C);
    assign timer_clr = accept || finish;

    always_comb begin
        amp = '0;
        if (st == RS_BUSY) begin
            amp.buf_en = 1'b1;
            if (phase == PH_RAMP) begin
                amp.pa_en  = (cnt >= LEAD_C);
                amp.mod_en = (cnt >= DLY_C);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RS_OFF;
            phase    <= PH_RAMP;
            origin   <= RS_PLL;
            tx_done  <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            if (st == RS_BUSY && req.start) err_flag <= 1'b1;
            else if (err_clr)               err_flag <= 1'b0;

            if (st == RS_BUSY) begin
                if (finish) begin
                    phase <= PH_FALL;
                end else if (fall_end) begin
                    st      <= origin;
                    phase   <= PH_RAMP;
                    tx_done <= 1'b1;
                end
            end else if (accept) begin
                origin <= st;
                st     <= RS_BUSY;
                phase  <= PH_RAMP;
            end else if (req.go_valid) begin
                st <= req.go_tgt;
            end
        end
    end

    // R3: busy is only ever entered from one of the two ready states
    assert_busy_from_ready_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(st == RS_BUSY) |-> ($past(st) == RS_PLL || $past(st) == RS_RETRY));

    // R5: the amplifier is never on without its buffer
    assert_pa_needs_buf_R5: assert property (@(posedge clk) disable iff (rst)
        amp.pa_en |-> amp.buf_en);

    // R5: buffer and amplifier never switch on together
    assert_buf_leads_pa_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(amp.buf_en) |-> !amp.pa_en);

    // R7: the buffer only drops after the amplifier is already off
    assert_pa_drops_first_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(amp.buf_en) |-> !$past(amp.pa_en));

    // R8: a start while busy always leaves the error flag set
    assert_busy_req_err_R8: assert property (@(posedge clk) disable iff (rst)
        (st == RS_BUSY && req.start) |=> err_flag);

    // R10: state commands cannot leave busy-transmit early
    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (st == RS_BUSY && phase == PH_RAMP && !finish) |=> st == RS_BUSY);

endmodule

// File: rtl/tx_start_seq.sv
module tx_start_seq
    import tx_seq_pkg::*;
#(
    parameter int unsigned START_DLY = 256,
    parameter int unsigned BUF_LEAD  = 128,
    parameter int unsigned FALL_GAP  = 4,
    localparam int unsigned CW       = $clog2(START_DLY + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_in,
    input  logic       cmd_we,
    input  logic [7:0] cmd_val,
    input  logic       frame_ok,
    input  logic       mod_done,
    input  logic       err_clr,
    output logic [7:0] state_code,
    output logic       pa_buf_en,
    output logic       pa_en,
    output logic       mod_en,
    output logic       tx_done,
    output logic       err_flag
);
    tx_req_t       req;
    radio_st_e     st;
    amp_ctl_t      amp;
    logic          timer_clr;
    logic [CW-1:0] cnt;

    tx_seq_trigger u_trig (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .cmd_we  (cmd_we),
        .cmd_val (cmd_val),
        .req     (req)
    );

    tx_seq_timer #(.LIMIT(START_DLY)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (timer_clr),
        .cnt (cnt)
    );

    tx_seq_ctrl #(
        .START_DLY (START_DLY),
        .BUF_LEAD  (BUF_LEAD),
        .FALL_GAP  (FALL_GAP)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .frame_ok  (frame_ok),
        .mod_done  (mod_done),
        .err_clr   (err_clr),
        .cnt       (cnt),
        .timer_clr (timer_clr),
        .st        (st),
        .amp       (amp),
        .tx_done   (tx_done),
        .err_flag  (err_flag)
    );

    assign state_code = st_to_code(st);
    assign pa_buf_en  = amp.buf_en;
    assign pa_en      = amp.pa_en;
    assign mod_en     = amp.mod_en;

    initial begin
        if (BUF_LEAD == 0 || BUF_LEAD >= START_DLY || FALL_GAP == 0 || FALL_GAP > START_DLY)
            $error("tx_start_seq: need 0 < BUF_LEAD < START_DLY and 0 < FALL_GAP <= START_DLY");
    end

endmodule

// File: tb/tx_start_seq_test.sv
module tx_start_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int SD = 20;
    localparam int BL = 7;
    localparam int FG = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       trig_in, cmd_we, frame_ok, mod_done, err_clr;
    logic [7:0] cmd_val;
    logic [7:0] state_code;
    logic       pa_buf_en, pa_en, mod_en, tx_done, err_flag;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_start_seq #(.START_DLY(SD), .BUF_LEAD(BL), .FALL_GAP(FG)) uut (
        .clk(clk), .rst(rst), .trig_in(trig_in), .cmd_we(cmd_we), .cmd_val(cmd_val),
        .frame_ok(frame_ok), .mod_done(mod_done), .err_clr(err_clr),
        .state_code(state_code), .pa_buf_en(pa_buf_en), .pa_en(pa_en),
        .mod_en(mod_en), .tx_done(tx_done), .err_flag(err_flag)
    );

    function automatic logic [7:0] exp_code(input bit retry);
        return retry ? 8'h19 : 8'h09;
    endfunction

    function automatic logic exp_pa(input int k);
        return k >= BL;
    endfunction

    function automatic logic exp_mod(input int k);
        return k >= SD;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_cmd(input logic [7:0] c);
        cmd_we = 1'b1; cmd_val = c;
        tick();
        cmd_we = 1'b0; cmd_val = 8'h00;
    endtask

    // full transmission; returns after completion pulse is checked
    task automatic run_tx(input bit retry, input bit use_trig, input int wait_n,
                          input bit inject, input bit early_done);
        int k;
        write_cmd(exp_code(retry));
        chk("R2 ready code", state_code, exp_code(retry));
        frame_ok = 1'b1;
        if (use_trig) begin trig_in = 1'b1; tick(); end
        else write_cmd(8'h02);
        k = 0;
        chk("R3 busy code", state_code, 8'h12);
        chk("R5 buf on at accept", pa_buf_en, 1);
        chk("R5 pa off at accept", pa_en, 0);
        if (early_done) begin
            mod_done = 1'b1; tick(); mod_done = 1'b0; k++;
            chk("R9 early done ignored", {state_code, pa_buf_en, mod_en}, {8'h12, 1'b1, 1'b0});
        end
        while (k < BL - 1) begin tick(); k++; end
        chk("R5 pa before lead", pa_en, exp_pa(k));
        tick(); k++;
        chk("R5 pa at lead", pa_en, exp_pa(k));
        while (k < SD - 1) begin tick(); k++; end
        chk("R6 mod before delay", mod_en, exp_mod(k));
        tick(); k++;
        chk("R6 mod at delay", mod_en, exp_mod(k));
        trig_in = 1'b0;
        repeat (wait_n) tick();
        if (inject) begin
            write_cmd(8'h02);
            chk("R8 err set", err_flag, 1);
            chk("R8 tx undisturbed", {state_code, pa_en, mod_en}, {8'h12, 1'b1, 1'b1});
            err_clr = 1'b1; tick(); err_clr = 1'b0;
            chk("R8 err cleared", err_flag, 0);
        end
        mod_done = 1'b1; tick(); mod_done = 1'b0;
        chk("R7 pa/mod off, buf on", {pa_en, mod_en, pa_buf_en}, 3'b001);
        chk("R7 still busy", state_code, 8'h12);
        repeat (FG - 1) tick();
        chk("R7 buf held", pa_buf_en, 1);
        tick();
        chk("R7 back to origin", state_code, exp_code(retry));
        chk("R7 buf off", pa_buf_en, 0);
        chk("R7 done pulse", tx_done, 1);
        tick();
        chk("R7 done one cycle", tx_done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1357);
        rst = 1'b1; trig_in = 0; cmd_we = 0; cmd_val = 0; frame_ok = 0; mod_done = 0; err_clr = 0;
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 reset code", state_code, 8'h08);
        chk("R1 reset outputs", {pa_buf_en, pa_en, mod_en, tx_done, err_flag}, 0);

        // R3: start from off is ignored
        frame_ok = 1'b1;
        write_cmd(8'h02);
        chk("R3 start in off ignored", {state_code, pa_buf_en, err_flag}, {8'h08, 2'b00});

        // R2: unknown command ignored
        write_cmd(8'h09);
        write_cmd(8'h33);
        chk("R2 unknown cmd", state_code, 8'h09);

        // R3: frame not valid blocks start
        frame_ok = 1'b0;
        trig_in = 1'b1; tick(); trig_in = 1'b0; tick();
        chk("R3 frame_ok low ignored", {state_code, pa_buf_en}, {8'h09, 1'b0});

        // R4: held trigger does not restart; R10 state cmd in busy
        run_tx(1'b0, 1'b1, 0, 1'b0, 1'b0);
        trig_in = 1'b1; frame_ok = 1'b1; tick(); // edge -> new tx
        chk("R4 trig edge starts", state_code, 8'h12);
        write_cmd(8'h08);
        chk("R10 cmd in busy ignored", state_code, 8'h12);
        repeat (SD) tick();
        mod_done = 1'b1; tick(); mod_done = 1'b0;
        repeat (FG) tick();
        chk("R10 origin kept", state_code, 8'h09);
        repeat (6) tick();
        chk("R4 held high no restart", {state_code, pa_buf_en}, {8'h09, 1'b0});
        trig_in = 1'b0; tick();

        // R8: set wins over clear in the same cycle
        trig_in = 1'b1; tick();
        cmd_we = 1'b1; cmd_val = 8'h02; err_clr = 1'b1; tick();
        cmd_we = 1'b0; err_clr = 1'b0;
        chk("R8 set wins", err_flag, 1);
        err_clr = 1'b1; tick(); err_clr = 1'b0; trig_in = 1'b0;
        chk("R8 clear", err_flag, 0);
        repeat (SD) tick();
        mod_done = 1'b1; tick(); mod_done = 1'b0;
        repeat (FG + 1) tick();

        // R9 directed
        run_tx(1'b1, 1'b0, 2, 1'b0, 1'b1);

        // random mix
        for (int i = 0; i < 40; i++) begin
            bit r_retry, r_trig, r_inj, r_early;
            int r_wait;
            r_retry = 1'($urandom());
            r_trig  = 1'($urandom());
            r_inj   = ($urandom() % 3) == 0;
            r_early = ($urandom() % 4) == 0;
            r_wait  = int'($urandom() % 6);
            if (($urandom() % 5) == 0) begin
                write_cmd(exp_code(r_retry));
                frame_ok = 1'b0;
                write_cmd(8'h02);
                chk("R3 random frame_ok low", {state_code, pa_buf_en}, {exp_code(r_retry), 1'b0});
            end
            run_tx(r_retry, r_trig, r_wait, r_inj, r_early);
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule